// File: doc/BRIEF.md
# Disk Write Channel Safety Controller

This block is the digital decision logic for one magnetic disk write path. It turns a stream of double-frequency write pulses into two complementary drive signals. Each signal steers current into one half of a centre-tapped head coil. A flip-flop changes phase on every pulse, so every pulse reverses the recorded flux. The block also enables the erase current source. It picks a high or a reduced write-current level from the cylinder address, and the density mode sets the threshold for that choice.

A legality monitor runs in parallel with the drive logic. It raises an emergency unload request when more than one head is selected. It also raises the request when current is sensed in the write or erase circuit while that circuit has not been enabled. The request stays latched until software clears it and the fault is gone. While latched, the request forces every drive off. All inputs except the clear strobe are asynchronous, so each one passes through a two-stage synchronizer. Write pulses are converted to single-cycle events with an edge detector in the system clock domain.

All pins are plain control and status levels. No pin carries a stream with a valid/ready handshake, so there is no back-pressure. A write pulse that arrives outside an active write is simply not acted on.

Top module: `wrchan_guard`

## Requirements
- R1: `coil_a` and `coil_b` are never high together. During an active write, each rising edge of `wdf_pulse` moves the drive from one coil half to the other.
- R2: When the synchronized `wr_mode_n` or `wr_en_n` is high, both coil outputs are low and the phase resets. The first drive of every write is therefore on `coil_a`.
- R3: Without an emergency, `erase_drive` is high when the synchronized `erase_en_n` is low or a write is active, and low otherwise.
- R4: When `dense_mode` is 0, `level_hi` is 1 for cylinders 0..127 and 0 for cylinders 128 and above. When `dense_mode` is 1, the threshold moves to 256.
- R5: `level_hi` follows the cylinder address only while write mode is inactive. During a write it holds its value.
- R6: If two or more `head_sel` bits are high at once, `emerg_req` is set. A single selected head, or none, raises nothing.
- R7: `emerg_req` is set when `wr_cur_sense` is high while write mode is inactive. It is also set when `er_cur_sense` is high while both erase enable and write mode are inactive.
- R8: Once set, `emerg_req` stays high until `emerg_clr` is high in a cycle with no fault present. A clear pulse issued while a fault persists leaves the request set.
- R9: While `emerg_req` is high, `coil_a`, `coil_b` and `erase_drive` are all low.
- R10: An input change reaches the outputs through two synchronizer stages. A change in write mode shows on the coils after the second rising clock edge and not after the first. A fault shows on `emerg_req` after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Write enable, active low, asynchronous |
| wr_mode_n | input | 1 | Write mode, active low, asynchronous |
| erase_en_n | input | 1 | Erase enable, active low, asynchronous |
| wdf_pulse | input | 1 | Double-frequency write pulse, asynchronous |
| head_sel | input | HEADS | Head select vector, expected one-hot or zero |
| cyl_addr | input | CYL_W | Positioner cylinder address |
| dense_mode | input | 1 | 0 = 100 tpi threshold, 1 = 200 tpi threshold |
| wr_cur_sense | input | 1 | Write current detected |
| er_cur_sense | input | 1 | Erase current detected |
| emerg_clr | input | 1 | Synchronous clear of the emergency latch |
| coil_a | output | 1 | Drive for coil half A |
| coil_b | output | 1 | Drive for coil half B |
| erase_drive | output | 1 | Erase current enable |
| level_hi | output | 1 | 1 = high write current, 0 = reduced |
| emerg_req | output | 1 | Latched emergency unload request, active high |

## Verification
In one cycle the emergency latch may be setting while the coil drive is running from an active write. The bench provokes this by opening a write, driving pulses until coil B conducts, and then asserting two head selects. It judges the result by requiring both coil outputs and the erase drive to fall on the same edge that sets `emerg_req`. A second collision occurs when a clear pulse arrives while a sensed-current fault is still present. There the request must stay set, and it must drop only once the clear comes after the fault is gone.

// File: rtl/wrchan_pkg.sv
package wrchan_pkg;

  typedef enum logic {
    PHASE_A = 1'b0,
    PHASE_B = 1'b1
  } coil_phase_e;

  typedef struct packed {
    logic multi_head;
    logic wr_leak;
    logic er_leak;
  } fault_t;

  // Index of each single-bit control in the synchronized bundle.
  localparam int unsigned CB_WR_EN_N   = 0;
  localparam int unsigned CB_WR_MODE_N = 1;
  localparam int unsigned CB_ERASE_N   = 2;
  localparam int unsigned CB_PULSE     = 3;
  localparam int unsigned CB_WCUR      = 4;
  localparam int unsigned CB_ECUR      = 5;
  localparam int unsigned CB_DENSE     = 6;
  localparam int unsigned CB_WIDTH     = 7;

endpackage

// File: rtl/wrchan_sync.sv
module wrchan_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wrchan_coil.sv
module wrchan_coil
  import wrchan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_s,
  input  logic drive_en,
  output logic coil_a,
  output logic coil_b
);

  logic        pulse_prev;
  logic        pulse_rise;
  coil_phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_prev <= 1'b0;
    else        pulse_prev <= pulse_s;
  end

  assign pulse_rise = pulse_s & ~pulse_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PHASE_A;
    end else if (!drive_en) begin
      phase <= PHASE_A;
    end else if (pulse_rise) begin
      phase <= (phase == PHASE_A) ? PHASE_B : PHASE_A;
    end
  end

  assign coil_a = drive_en & (phase == PHASE_A);
  assign coil_b = drive_en & (phase == PHASE_B);

  // R2: an idle cycle leaves the phase at A for the next write
  assert_phase_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> (phase == PHASE_A));

  // R1: an edge during a drive reverses the phase
  assert_pulse_flips_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && pulse_rise) |=> (drive_en -> (phase != $past(phase))) || !drive_en);

endmodule

// File: rtl/wrchan_level.sv
module wrchan_level #(
  parameter int unsigned CYL_W      = 10,
  parameter int unsigned THR_SPARSE = 128,
  parameter int unsigned THR_DENSE  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYL_W-1:0] cyl,
  input  logic             dense,
  input  logic             idle,
  output logic             level_hi
);

  localparam logic [CYL_W:0] LIM_SPARSE = (CYL_W+1)'(THR_SPARSE);
  localparam logic [CYL_W:0] LIM_DENSE  = (CYL_W+1)'(THR_DENSE);

  logic [CYL_W:0] limit;
  logic           want_hi;

  assign limit   = dense ? LIM_DENSE : LIM_SPARSE;
  assign want_hi = ({1'b0, cyl} < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level_hi <= 1'b1;
    else if (idle) level_hi <= want_hi;
  end

  // R5: no level change during a write
  assert_level_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(level_hi));

endmodule

// File: rtl/wrchan_monitor.sv
module wrchan_monitor
  import wrchan_pkg::*;
#(
  parameter int unsigned HEADS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HEADS-1:0] head_s,
  input  logic             mode_n_s,
  input  logic             erase_n_s,
  input  logic             wcur_s,
  input  logic             ecur_s,
  input  logic             clr,
  output logic             emerg
);

  fault_t flt;
  logic   any_fault;

  assign flt.multi_head = ($countones(head_s) > 1);
  assign flt.wr_leak    = wcur_s & mode_n_s;
  assign flt.er_leak    = ecur_s & erase_n_s & mode_n_s;
  assign any_fault      = |flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         emerg <= 1'b0;
    else if (any_fault) emerg <= 1'b1;
    else if (clr)       emerg <= 1'b0;
  end

  assert_multi_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(head_s) > 1) |=> emerg);

  assert_sense_leak_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wcur_s && mode_n_s) || (ecur_s && erase_n_s && mode_n_s)) |=> emerg);

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emerg && !clr) |=> emerg);

endmodule

// File: rtl/wrchan_guard.sv
module wrchan_guard
  import wrchan_pkg::*;
#(
  parameter int unsigned HEADS       = 4,
  parameter int unsigned CYL_W       = 10,
  parameter int unsigned THR_SPARSE  = 128,
  parameter int unsigned THR_DENSE   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic             wr_mode_n,
  input  logic             erase_en_n,
  input  logic             wdf_pulse,
  input  logic [HEADS-1:0] head_sel,
  input  logic [CYL_W-1:0] cyl_addr,
  input  logic             dense_mode,
  input  logic             wr_cur_sense,
  input  logic             er_cur_sense,
  input  logic             emerg_clr,
  output logic             coil_a,
  output logic             coil_b,
  output logic             erase_drive,
  output logic             level_hi,
  output logic             emerg_req
);

  localparam logic [CB_WIDTH-1:0] CB_RST =
    CB_WIDTH'((1 << CB_WR_EN_N) | (1 << CB_WR_MODE_N) | (1 << CB_ERASE_N));

  logic [CB_WIDTH-1:0] ctl_raw, ctl_s;
  logic [HEADS-1:0]    head_s;
  logic [CYL_W-1:0]    cyl_s;
  logic                write_act;

  always_comb begin
    ctl_raw               = '0;
    ctl_raw[CB_WR_EN_N]   = wr_en_n;
    ctl_raw[CB_WR_MODE_N] = wr_mode_n;
    ctl_raw[CB_ERASE_N]   = erase_en_n;
    ctl_raw[CB_PULSE]     = wdf_pulse;
    ctl_raw[CB_WCUR]      = wr_cur_sense;
    ctl_raw[CB_ECUR]      = er_cur_sense;
    ctl_raw[CB_DENSE]     = dense_mode;
  end

  wrchan_sync #(.W(CB_WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(CB_RST)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

  wrchan_sync #(.W(HEADS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_head (
    .clk(clk), .rst_n(rst_n), .d(head_sel), .q(head_s));

  wrchan_sync #(.W(CYL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_cyl (
    .clk(clk), .rst_n(rst_n), .d(cyl_addr), .q(cyl_s));

  wrchan_monitor #(.HEADS(HEADS)) u_mon (
    .clk(clk), .rst_n(rst_n), .head_s(head_s),
    .mode_n_s(ctl_s[CB_WR_MODE_N]), .erase_n_s(ctl_s[CB_ERASE_N]),
    .wcur_s(ctl_s[CB_WCUR]), .ecur_s(ctl_s[CB_ECUR]),
    .clr(emerg_clr), .emerg(emerg_req));

  assign write_act = ~ctl_s[CB_WR_MODE_N] & ~ctl_s[CB_WR_EN_N] & ~emerg_req;

  wrchan_coil u_coil (
    .clk(clk), .rst_n(rst_n), .pulse_s(ctl_s[CB_PULSE]),
    .drive_en(write_act), .coil_a(coil_a), .coil_b(coil_b));

  wrchan_level #(.CYL_W(CYL_W), .THR_SPARSE(THR_SPARSE), .THR_DENSE(THR_DENSE)) u_level (
    .clk(clk), .rst_n(rst_n), .cyl(cyl_s), .dense(ctl_s[CB_DENSE]),
    .idle(ctl_s[CB_WR_MODE_N]), .level_hi(level_hi));

  assign erase_drive = ~emerg_req & (~ctl_s[CB_ERASE_N] | write_act);

  assert_coils_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(coil_a && coil_b));

  assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_s[CB_WR_MODE_N] || ctl_s[CB_WR_EN_N]) |-> (!coil_a && !coil_b));

  assert_erase_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coil_a || coil_b) |-> erase_drive);

  assert_emerg_forces_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_req |-> (!coil_a && !coil_b && !erase_drive));

endmodule

// File: tb/wrchan_guard_test.sv
`timescale 1ns/1ps
module wrchan_guard_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_n = 1'b1, wr_mode_n = 1'b1, erase_en_n = 1'b1, wdf_pulse = 1'b0;
  logic [3:0] head_sel = 4'b0001;
  logic [9:0] cyl_addr = '0;
  logic       dense_mode = 1'b0, wr_cur_sense = 1'b0, er_cur_sense = 1'b0, emerg_clr = 1'b0;
  logic       coil_a, coil_b, erase_drive, level_hi, emerg_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  wrchan_guard uut (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_mode_n(wr_mode_n),
    .erase_en_n(erase_en_n), .wdf_pulse(wdf_pulse), .head_sel(head_sel),
    .cyl_addr(cyl_addr), .dense_mode(dense_mode), .wr_cur_sense(wr_cur_sense),
    .er_cur_sense(er_cur_sense), .emerg_clr(emerg_clr),
    .coil_a(coil_a), .coil_b(coil_b), .erase_drive(erase_drive),
    .level_hi(level_hi), .emerg_req(emerg_req));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_once();
    wdf_pulse = 1'b1; wait_n(3);
    wdf_pulse = 1'b0; wait_n(3);
  endtask

  task automatic clear_emerg();
    emerg_clr = 1'b1; wait_n(1);
    emerg_clr = 1'b0; wait_n(1);
  endtask

  task automatic t_reset();
    check("R2 reset coil_a", coil_a, 1'b0);
    check("R2 reset coil_b", coil_b, 1'b0);
    check("R3 reset erase", erase_drive, 1'b0);
    check("R4 reset level", level_hi, 1'b1);
    check("R8 reset emerg", emerg_req, 1'b0);
  endtask

  task automatic t_write_toggle();
    wr_en_n = 1'b0; wr_mode_n = 1'b0;
    wait_n(1);
    check("R10 coil_a after one edge", coil_a, 1'b0);
    wait_n(1);
    check("R2 first half A", coil_a, 1'b1);
    check("R3 erase during write", erase_drive, 1'b1);
    pulse_once();
    check("R1 pulse1 coil_b", coil_b, 1'b1);
    check("R1 pulse1 coil_a", coil_a, 1'b0);
    pulse_once();
    check("R1 pulse2 coil_a", coil_a, 1'b1);
    pulse_once();
    check("R1 pulse3 coil_b", coil_b, 1'b1);
    wr_mode_n = 1'b1; wait_n(4);
    check("R2 idle coil_a", coil_a, 1'b0);
    check("R2 idle coil_b", coil_b, 1'b0);
    check("R3 erase off idle", erase_drive, 1'b0);
    pulse_once();
    check("R2 pulse idle ignored", coil_a | coil_b, 1'b0);
    wr_mode_n = 1'b0; wait_n(4);
    check("R2 restart on A", coil_a, 1'b1);
    wr_en_n = 1'b1; wait_n(4);
    check("R2 wr_en high drops drive", coil_a | coil_b, 1'b0);
    wr_mode_n = 1'b1; wait_n(4);
  endtask

  task automatic t_erase_only();
    erase_en_n = 1'b0; wait_n(4);
    check("R3 erase only on", erase_drive, 1'b1);
    check("R3 erase only no coil", coil_a | coil_b, 1'b0);
    erase_en_n = 1'b1; wait_n(4);
    check("R3 erase only off", erase_drive, 1'b0);
  endtask

  task automatic t_level();
    dense_mode = 1'b0; cyl_addr = 10'd127; wait_n(4);
    check("R4 sparse 127", level_hi, 1'b1);
    cyl_addr = 10'd128; wait_n(4);
    check("R4 sparse 128", level_hi, 1'b0);
    dense_mode = 1'b1; wait_n(4);
    check("R4 dense 128", level_hi, 1'b1);
    cyl_addr = 10'd255; wait_n(4);
    check("R4 dense 255", level_hi, 1'b1);
    cyl_addr = 10'd256; wait_n(4);
    check("R4 dense 256", level_hi, 1'b0);
    dense_mode = 1'b0; cyl_addr = 10'd1023; wait_n(4);
    check("R4 sparse 1023", level_hi, 1'b0);
    wr_en_n = 1'b0; wr_mode_n = 1'b0; wait_n(4);
    cyl_addr = 10'd5; wait_n(4);
    check("R5 frozen in write", level_hi, 1'b0);
    wr_mode_n = 1'b1; wr_en_n = 1'b1; wait_n(4);
    check("R5 updates after write", level_hi, 1'b1);
    cyl_addr = 10'd0; wait_n(4);
  endtask

  task automatic t_multi_head();
    head_sel = 4'b0100; wait_n(4);
    check("R6 single head ok", emerg_req, 1'b0);
    head_sel = 4'b0000; wait_n(4);
    check("R6 no head ok", emerg_req, 1'b0);
    head_sel = 4'b0001;
    wr_en_n = 1'b0; wr_mode_n = 1'b0; wait_n(4);
    pulse_once();
    check("R1 setup coil_b", coil_b, 1'b1);
    head_sel = 4'b0011;
    wait_n(2);
    check("R10 emerg after two edges", emerg_req, 1'b0);
    check("R10 drive still on", coil_b, 1'b1);
    wait_n(1);
    check("R6 multi head emerg", emerg_req, 1'b1);
    check("R9 coil_b forced off", coil_b, 1'b0);
    check("R9 coil_a forced off", coil_a, 1'b0);
    check("R9 erase forced off", erase_drive, 1'b0);
    head_sel = 4'b0001; wait_n(4);
    check("R8 latched after fault gone", emerg_req, 1'b1);
    wr_mode_n = 1'b1; wr_en_n = 1'b1; wait_n(4);
    clear_emerg();
    check("R8 cleared", emerg_req, 1'b0);
  endtask

  task automatic t_sense();
    wr_cur_sense = 1'b1; wait_n(4);
    check("R7 write leak", emerg_req, 1'b1);
    clear_emerg();
    check("R8 clear blocked by fault", emerg_req, 1'b1);
    wr_cur_sense = 1'b0; wait_n(4);
    clear_emerg();
    check("R8 clear after fault gone", emerg_req, 1'b0);
    er_cur_sense = 1'b1; wait_n(4);
    check("R7 erase leak", emerg_req, 1'b1);
    er_cur_sense = 1'b0; wait_n(4);
    clear_emerg();
    erase_en_n = 1'b0; wait_n(4);
    er_cur_sense = 1'b1; wait_n(4);
    check("R7 erase current enabled ok", emerg_req, 1'b0);
    er_cur_sense = 1'b0; erase_en_n = 1'b1;
    wr_mode_n = 1'b0; wait_n(4);
    wr_cur_sense = 1'b1; er_cur_sense = 1'b1; wait_n(4);
    check("R7 currents in write ok", emerg_req, 1'b0);
    wr_cur_sense = 1'b0; er_cur_sense = 1'b0; wr_mode_n = 1'b1; wait_n(4);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_write_toggle();
    t_erase_only();
    t_level();
    t_multi_head();
    t_sense();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule